// File: doc/BRIEF.md
# Privileged Status and Control Register Bank

This block holds the control-register state of a small processor core: six 32-bit registers selected by a 3-bit index. Register 0 is the live status word. Its bit 0 is the interrupt-enable flag, and its bit 1 is the mode flag, where 1 means user and 0 means supervisor. Register 1 is the saved-status register. It keeps the same two bits as they stood just before the most recent exception. Registers 2 to 5 are plain 32-bit storage.

The pipeline sends read and write requests carrying an index. The bank serves them only while the core is in supervisor mode. A request made in user mode changes nothing and raises a one-cycle privilege-fault flag instead. An exception-entry pulse saves the status word and drops to supervisor mode with interrupts off. An exception-return pulse restores the saved word. The bank drives the current mode and an interrupt-accept line, which is the external request gated by the enable flag.

Top module: `ctrl_state_bank`

## Requirements
- R1: After reset, user_mode is 0, irq_accept is 0 even with irq_req high, priv_fault is 0, and every register reads as zero.
- R2: In supervisor mode, a write with index 0 to 5 updates the selected register on the next clock. rd_data combinationally returns the value of the register selected by rd_req and reg_idx. Registers 0 and 1 keep only bits 1:0 (bit 0 enable, bit 1 mode) and read zero above them. Registers 2 to 5 keep all 32 bits.
- R3: In user mode, writes leave every register unchanged, and reads return zero on rd_data.
- R4: A cycle with rd_req or wr_req high in user mode makes priv_fault high in the following cycle. priv_fault is low after any cycle without such an access.
- R5: user_mode always equals bit 1 of register 0.
- R6: irq_accept is irq_req ANDed with bit 0 of register 0, with no clock delay.
- R7: On an exc_enter cycle, register 1 takes the old bits 1:0 of register 0 on the next clock, and register 0 becomes 0, which means supervisor mode with interrupts disabled.
- R8: On an exc_return cycle without exc_enter, register 0 takes the value of register 1 on the next clock.
- R9: exc_enter has priority over exc_return. Any control write made in the same cycle as either pulse is dropped.
- R10: Indexes 6 and 7 name no register. Writes to them are ignored, reads of them return zero, and in supervisor mode they raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Control read request |
| wr_req | input | 1 | Control write request |
| reg_idx | input | 3 | Register index for the read or write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero unless the read is permitted |
| exc_enter | input | 1 | Exception-entry pulse |
| exc_return | input | 1 | Exception-return pulse |
| irq_req | input | 1 | External interrupt request |
| irq_accept | output | 1 | Interrupt request gated by the enable bit |
| user_mode | output | 1 | Current mode, 1 means user |
| priv_fault | output | 1 | One-cycle flag for a user-mode control access |

## Verification
A vector table drives the status word through several patterns: supervisor writes, user-mode writes and reads, single entry and return pulses, both pulses in the same cycle, and a pulse arriving together with a write. Comparing mode, accept and fault after each step shows whether privilege gating, save and restore, and pulse priority are each correct. Directed steps then write distinct bit patterns into registers 2 to 5, including all-ones and a lone top bit, to separate full-width storage from the two-bit status masking. They also probe the unused indexes and check that a user-mode access leaves the stored data intact once supervisor mode returns.

// File: rtl/csb_pkg.sv
package csb_pkg;
    localparam int STAT_W  = 2;
    localparam int PIE_POS = 0;
    localparam int MODE_POS = 1;

    typedef logic [STAT_W-1:0] stat_t;

    typedef struct packed {
        stat_t live;
        stat_t saved;
    } stat_state_t;

    typedef struct packed {
        logic fault;
    } gate_state_t;
endpackage

// File: rtl/csb_status_unit.sv
module csb_status_unit
    import csb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_live,
    input  logic  wr_saved,
    input  stat_t wdata,
    input  logic  exc_enter,
    input  logic  exc_return,
    output stat_t live,
    output stat_t saved
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (exc_enter) begin
            st_d.saved = st_q.live;
            st_d.live  = '0;
        end else if (exc_return) begin
            st_d.live = st_q.saved;
        end else begin
            if (wr_live)  st_d.live  = wdata;
            if (wr_saved) st_d.saved = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live  = st_q.live;
    assign saved = st_q.saved;

    // R7
    exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (live == '0 && saved == $past(live)));

    // R8
    exc_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=> live == $past(saved));

    // R2
    live_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && !exc_enter && !exc_return) |=> live == $past(wdata));

    // R3
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_live && !exc_enter && !exc_return) |=> $stable(live));
endmodule

// File: rtl/csb_general_regs.sv
module csb_general_regs #(
    parameter int DATA_W  = 32,
    parameter int NUM_GEN = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_GEN-1:0]             we,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_GEN-1:0][DATA_W-1:0] regs
);
    logic [NUM_GEN-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (we[i]) regs_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        // R3
        gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we[g] |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/csb_access_gate.sv
module csb_access_gate
    import csb_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic [IDX_W-1:0]    idx,
    input  logic                user,
    input  logic                exc_busy,
    output logic                rd_ok,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic                priv_fault
);
    gate_state_t gs_d, gs_q;
    logic idx_valid;

    assign idx_valid = (32'(idx) < NUM_REGS);
    assign rd_ok     = rd_req && !user && idx_valid;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wr_sel[i] = wr_req && !user && !exc_busy && (idx == IDX_W'(i));
    end

    always_comb begin
        gs_d       = gs_q;
        gs_d.fault = (rd_req || wr_req) && user;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gs_q <= '0;
        else        gs_q <= gs_d;
    end

    assign priv_fault = gs_q.fault;

    // R4
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || wr_req) && user) |=> priv_fault);

    // R4
    fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_req || wr_req) && user) |=> !priv_fault);
endmodule

// File: rtl/ctrl_state_bank.sv
module ctrl_state_bank
    import csb_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 6,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              irq_req,
    output logic              irq_accept,
    output logic              user_mode,
    output logic              priv_fault
);
    localparam int NUM_GEN = NUM_REGS - 2;

    stat_t                          live, saved;
    logic                           rd_ok;
    logic [NUM_REGS-1:0]            wr_sel;
    logic [NUM_GEN-1:0][DATA_W-1:0] gen_regs;
    logic [DATA_W-1:0]              view [NUM_REGS];

    csb_access_gate #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .idx        (reg_idx),
        .user       (user_mode),
        .exc_busy   (exc_enter || exc_return),
        .rd_ok      (rd_ok),
        .wr_sel     (wr_sel),
        .priv_fault (priv_fault)
    );

    csb_status_unit u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_live    (wr_sel[0]),
        .wr_saved   (wr_sel[1]),
        .wdata      (wr_data[STAT_W-1:0]),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .live       (live),
        .saved      (saved)
    );

    csb_general_regs #(.DATA_W(DATA_W), .NUM_GEN(NUM_GEN)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_sel[NUM_REGS-1:2]),
        .wdata (wr_data),
        .regs  (gen_regs)
    );

    always_comb begin
        view[0] = DATA_W'(live);
        view[1] = DATA_W'(saved);
        for (int i = 0; i < NUM_GEN; i++) view[i+2] = gen_regs[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_ok && reg_idx == IDX_W'(i)) rd_data = view[i];
        end
    end

    assign user_mode  = live[MODE_POS];
    assign irq_accept = irq_req && live[PIE_POS];

    // R7
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (!irq_accept && !user_mode));

    // R3
    user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> rd_data == '0);
endmodule

// File: tb/ctrl_state_bank_test.sv
module ctrl_state_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        rd_req = 0, wr_req = 0, exc_enter = 0, exc_return = 0, irq_req = 0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_accept, user_mode, priv_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ctrl_state_bank uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
        .exc_enter(exc_enter), .exc_return(exc_return), .irq_req(irq_req),
        .irq_accept(irq_accept), .user_mode(user_mode), .priv_fault(priv_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [2:0]  idx;
        logic [31:0] data;
        logic        enter;
        logic        ret;
        logic        e_mode;
        logic        e_pie;
        logic        e_fault;
    } vec_t;

    // Each step: drive one cycle, then check mode, accept (irq held high) and fault.
    localparam vec_t VECS [12] = '{
        '{0,1,3'd0,32'h3,       0,0, 1,1,0}, // R2 supervisor write sets mode+enable
        '{0,1,3'd0,32'h0,       0,0, 1,1,1}, // R3 R4 user write ignored, fault
        '{1,0,3'd1,32'h0,       0,0, 1,1,1}, // R4 user read faults
        '{0,0,3'd0,32'h0,       1,0, 0,0,0}, // R7 entry clears status
        '{0,1,3'd0,32'h1,       0,0, 0,1,0}, // R2 enable only
        '{0,0,3'd0,32'h0,       0,1, 1,1,0}, // R8 return restores 3
        '{0,0,3'd0,32'h0,       1,1, 0,0,0}, // R9 entry beats return
        '{0,1,3'd0,32'h2,       0,1, 1,1,0}, // R9 write dropped on return
        '{0,1,3'd0,32'h1,       1,0, 0,0,1}, // R9 R4 user write + entry
        '{0,1,3'd0,32'hFFFFFFFC,0,0, 0,0,0}, // R2 upper bits masked
        '{0,1,3'd0,32'h2,       0,0, 1,0,0}, // R5 mode without enable
        '{0,0,3'd0,32'h0,       0,1, 1,1,0}  // R8 return restores saved 3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_req = 0; wr_req = 0; exc_enter = 0; exc_return = 0;
    endtask

    task automatic do_write(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_req = 1; reg_idx = i; wr_data = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_enter();
        @(negedge clk);
        exc_enter = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_chk(input string tag, input logic [2:0] i, input logic [31:0] exp);
        @(negedge clk);
        rd_req = 1; reg_idx = i;
        #1;
        chk(tag, rd_data, exp);
        rd_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        irq_req = 1;
        #1;
        // R1 reset state
        chk("R1 user_mode", {31'b0, user_mode}, 0);
        chk("R1 irq_accept", {31'b0, irq_accept}, 0);
        chk("R1 priv_fault", {31'b0, priv_fault}, 0);
        for (int i = 0; i < 6; i++) read_chk("R1 reg zero", 3'(i), 0);

        // Vector walk
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            rd_req = VECS[v].rd; wr_req = VECS[v].wr; reg_idx = VECS[v].idx;
            wr_data = VECS[v].data; exc_enter = VECS[v].enter; exc_return = VECS[v].ret;
            irq_req = 1;
            @(negedge clk);
            idle_inputs();
            #1;
            chk($sformatf("R5 vec%0d mode", v), {31'b0, user_mode}, {31'b0, VECS[v].e_mode});
            chk($sformatf("R6 vec%0d accept", v), {31'b0, irq_accept}, {31'b0, VECS[v].e_pie});
            chk($sformatf("R4 vec%0d fault", v), {31'b0, priv_fault}, {31'b0, VECS[v].e_fault});
        end

        // Directed: state is user, live=3, saved=3
        do_enter();
        read_chk("R7 saved copy", 3'd1, 32'h3);
        read_chk("R7 live cleared", 3'd0, 32'h0);

        do_write(3'd2, 32'hA5A50F0F);
        do_write(3'd3, 32'h00000001);
        do_write(3'd4, 32'hFFFFFFFF);
        do_write(3'd5, 32'h80000000);
        read_chk("R2 reg2", 3'd2, 32'hA5A50F0F);
        read_chk("R2 reg3", 3'd3, 32'h00000001);
        read_chk("R2 reg4", 3'd4, 32'hFFFFFFFF);
        read_chk("R2 reg5", 3'd5, 32'h80000000);

        do_write(3'd1, 32'hFFFFFFFF);
        read_chk("R2 saved masked", 3'd1, 32'h3);

        do_write(3'd6, 32'h0000DEAD);
        #1;
        chk("R10 no fault", {31'b0, priv_fault}, 0);
        read_chk("R10 idx6 zero", 3'd6, 0);
        read_chk("R10 idx7 zero", 3'd7, 0);
        chk("R10 mode untouched", {31'b0, user_mode}, 0);

        do_write(3'd0, 32'h1);
        irq_req = 0; #1;
        chk("R6 no request", {31'b0, irq_accept}, 0);
        irq_req = 1; #1;
        chk("R6 request accepted", {31'b0, irq_accept}, 1);

        do_write(3'd0, 32'h2);
        #1;
        chk("R5 user mode set", {31'b0, user_mode}, 1);
        chk("R6 enable off", {31'b0, irq_accept}, 0);

        do_write(3'd2, 32'h00001234);
        #1;
        chk("R4 fault raised", {31'b0, priv_fault}, 1);
        @(negedge clk); #1;
        chk("R4 fault one cycle", {31'b0, priv_fault}, 0);
        read_chk("R3 user read zero", 3'd2, 0);

        do_enter();
        read_chk("R3 reg2 kept", 3'd2, 32'hA5A50F0F);
        read_chk("R7 saved user", 3'd1, 32'h2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule